// File: doc/BRIEF.md
# Anode Wire-Group Muon Stub Finder

This block searches six layers of anode wire-group hits for short muon track segments and tags each one with a single bunch crossing. Every crossing it receives one hit bit per wire group per layer. Each bit is stretched over a programmable number of crossings, so hits spread out by drift time can still line up. For every wire group taken as the key position, the block counts the layers that are hit inside two envelopes at once. The collision envelope expects a bent track from the interaction point. The accelerator envelope expects a track running parallel to the beam.

Each key position has its own small sequencer. The sequencer arms (pretriggers) when a layer count reaches a low threshold. After a fixed confirmation delay it declares a stub if the count has reached a higher threshold. The crossing is therefore fixed by the first crossing in which the multi-layer coincidence forms. Stubs found in the same crossing are ranked, and at most two are reported. A mode input restricts the search to the accelerator envelope and flags the resulting stubs as veto candidates, so they are not used as triggers.

Top module: `wire_stub_finder`

## Requirements
- R1: While reset is asserted, and in the crossing after it is released, every output is 0.
- R2: A hit on `hits_i[l][w]` (l = layer 0..5, w = wire group) counts as present for `stretch_i` crossings starting with the crossing in which it is sampled. Hits sampled in different crossings combine while their stretched windows overlap. A hit no longer counts once its window has ended.
- R3: A key arms when its best layer count is at least the pretrigger minimum. The count is checked again CONFIRM_DLY crossings later, and the stub is declared only if it then meets the trigger minimum. The stub appears on the outputs for exactly one cycle, 1 + CONFIRM_DLY cycles after the arming crossing was sampled. An arming that fails its confirmation reports nothing.
- R4: Collision count of key k: layers 1–4 count a hit at wire group k. Layers 0 and 5 count a hit at wire group k−1 or k+1 (neighbours that do not exist are absent).
- R5: Accelerator count of key k: every layer counts a hit at wire group k only. A key reports its accelerator count with type bit 1 only when that count is strictly larger than its collision count. Otherwise it reports the collision count with type bit 0.
- R6: The pretrigger minimum and the trigger minimum are each taken from a 3-bit input. A value of 0 acts as 1, and a value of 7 acts as 6.
- R7: Stubs found in the same crossing are ordered by larger layer count, then collision type before accelerator type, then lower key wire group.
- R8: At most two stubs are reported per crossing, on slot 0 (best) and slot 1 (second). Slot 1 is valid only when slot 0 is valid.
- R9: When a stub is declared at key k, keys k−1, k and k+1 cannot arm again for `stretch_i` crossings, starting with the crossing after the declaration.
- R10: With `accel_only_i` = 1, only the accelerator count is evaluated, every stub carries type bit 1, and `veto_o` is 1 in each cycle that slot 0 is valid. With `accel_only_i` = 0, `veto_o` stays 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bunch-crossing clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| hits_i | input | 6 x NWG | Hit bits, indexed [layer][wire group] |
| stretch_i | input | SW | Hit stretch length in crossings |
| pre_min_i | input | 3 | Pretrigger layer minimum |
| trg_min_i | input | 3 | Trigger layer minimum |
| accel_only_i | input | 1 | Accelerator-only veto mode |
| s0_vld_o | output | 1 | Best stub valid |
| s0_key_o | output | KW | Best stub key wire group |
| s0_accel_o | output | 1 | Best stub type, 1 = accelerator |
| s0_nlyr_o | output | 3 | Best stub layer count |
| s1_vld_o | output | 1 | Second stub valid |
| s1_key_o | output | KW | Second stub key wire group |
| s1_accel_o | output | 1 | Second stub type, 1 = accelerator |
| s1_nlyr_o | output | 3 | Second stub layer count |
| veto_o | output | 1 | Reported stubs are veto candidates |

## Verification
The bench spreads one track over three crossings. A design that reported the crossing at confirmation rather than at arming, or that stretched hits too briefly, would move or drop that stub. It lays one track over two non-overlapping stretch windows, where an off-by-one in hit expiry would create a false stub. It places equal-count collision and accelerator tracks side by side, and adds a third track, to expose a ranking that ignored type or key order or that leaked a third stub. It also offers a new track to a blocked neighbour and to a free key at the same time. Wrong blocking would then either trigger the neighbour or suppress the free key. Threshold clamping, a pretrigger minimum that delays the reported crossing, and accelerator-only mode with a collision-only track are each checked at the ports.

// File: rtl/wsf_pkg.sv
package wsf_pkg;
  localparam int unsigned NLAYER = 6;

  // Outer layers accept a +/-1 wire-group offset in the collision envelope
  function automatic bit is_outer(input int unsigned l);
    return (l == 0) || (l == NLAYER - 1);
  endfunction

  // Map a programmed minimum onto the legal range 1..6
  function automatic logic [2:0] clamp_min(input logic [2:0] v);
    if (v == 3'd0)      return 3'd1;
    else if (v > 3'd6)  return 3'd6;
    else                return v;
  endfunction
endpackage

// File: rtl/wsf_stretch.sv
module wsf_stretch #(
  parameter int unsigned NWG = 16,
  parameter int unsigned SW  = 2
) (
  input  logic                                clk,
  input  logic                                rst_n,
  input  logic [wsf_pkg::NLAYER-1:0][NWG-1:0] hit_i,
  input  logic [SW-1:0]                       stretch_i,
  output logic [wsf_pkg::NLAYER-1:0][NWG-1:0] str_o
);
  localparam int unsigned NL = wsf_pkg::NLAYER;

  for (genvar l = 0; l < NL; l++) begin : g_lyr
    for (genvar w = 0; w < NWG; w++) begin : g_wg
      logic [SW-1:0] cnt_q, cnt_n;
      always_comb begin
        if (hit_i[l][w])        cnt_n = stretch_i;
        else if (cnt_q != '0)   cnt_n = cnt_q - 1'b1;
        else                    cnt_n = cnt_q;
      end
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cnt_q <= '0;
        else        cnt_q <= cnt_n;
      end
      assign str_o[l][w] = (cnt_q != '0);
    end
  end

  // R2
  stretch_needs_hit_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ((str_o & ~$past(str_o) & ~$past(hit_i)) == '0));
endmodule

// File: rtl/wsf_layer_count.sv
module wsf_layer_count #(
  parameter int unsigned NWG = 16
) (
  input  logic [wsf_pkg::NLAYER-1:0][NWG-1:0] str_i,
  output logic [2:0]                          coll_o [NWG],
  output logic [2:0]                          acc_o  [NWG]
);
  localparam int unsigned NL = wsf_pkg::NLAYER;

  for (genvar k = 0; k < NWG; k++) begin : g_key
    logic [NL-1:0] col_b, acc_b;
    for (genvar l = 0; l < NL; l++) begin : g_lyr
      logic lft, rgt;
      if (k > 0)       begin : g_l assign lft = str_i[l][k-1]; end
      else             begin : g_l0 assign lft = 1'b0; end
      if (k < NWG - 1) begin : g_r assign rgt = str_i[l][k+1]; end
      else             begin : g_r0 assign rgt = 1'b0; end
      assign acc_b[l] = str_i[l][k];
      if (wsf_pkg::is_outer(l)) begin : g_out
        assign col_b[l] = lft | rgt;
      end else begin : g_mid
        assign col_b[l] = str_i[l][k];
      end
    end
    always_comb begin
      coll_o[k] = '0;
      acc_o[k]  = '0;
      for (int l = 0; l < NL; l++) begin
        coll_o[k] = coll_o[k] + {2'b00, col_b[l]};
        acc_o[k]  = acc_o[k]  + {2'b00, acc_b[l]};
      end
    end
  end
endmodule

// File: rtl/wsf_key_engine.sv
module wsf_key_engine #(
  parameter int unsigned SW          = 2,
  parameter int unsigned CONFIRM_DLY = 1
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [2:0]    coll_i,
  input  logic [2:0]    acc_i,
  input  logic          accel_only_i,
  input  logic [2:0]    pre_min_i,
  input  logic [2:0]    trg_min_i,
  input  logic [SW-1:0] stretch_i,
  input  logic          blk_ld_i,
  output logic          fire_o,
  output logic [2:0]    cnt_o,
  output logic          accel_o
);
  localparam int unsigned DW = (CONFIRM_DLY > 1) ? $clog2(CONFIRM_DLY) : 1;

  typedef enum logic {ST_IDLE, ST_WAIT} st_e;
  st_e           st_q, st_n;
  logic [DW-1:0] dly_q, dly_n;
  logic [SW-1:0] blk_q, blk_n;
  logic          arm;

  always_comb begin
    if (accel_only_i || (acc_i > coll_i)) begin
      cnt_o   = acc_i;
      accel_o = 1'b1;
    end else begin
      cnt_o   = coll_i;
      accel_o = 1'b0;
    end
  end

  assign arm    = (blk_q == '0) && (cnt_o >= pre_min_i);
  assign fire_o = (st_q == ST_WAIT) && (dly_q == '0) && (cnt_o >= trg_min_i);

  always_comb begin
    st_n  = st_q;
    dly_n = dly_q;
    case (st_q)
      ST_IDLE: if (arm) begin
        st_n  = ST_WAIT;
        dly_n = DW'(CONFIRM_DLY - 1);
      end
      ST_WAIT: if (dly_q == '0) st_n = ST_IDLE;
               else             dly_n = dly_q - 1'b1;
      default: st_n = ST_IDLE;
    endcase
    if (blk_ld_i)          blk_n = stretch_i;
    else if (blk_q != '0)  blk_n = blk_q - 1'b1;
    else                   blk_n = blk_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q  <= ST_IDLE;
      dly_q <= '0;
      blk_q <= '0;
    end else begin
      st_q  <= st_n;
      dly_q <= dly_n;
      blk_q <= blk_n;
    end
  end

  // R3
  single_fire_per_arm_chk: assert property (@(posedge clk) disable iff (!rst_n)
    fire_o |=> !fire_o);
  // R6
  fire_meets_min_chk: assert property (@(posedge clk) disable iff (!rst_n)
    fire_o |-> (cnt_o >= trg_min_i) && (cnt_o != 3'd0));
endmodule

// File: rtl/wsf_ranker.sv
module wsf_ranker #(
  parameter int unsigned NWG = 16,
  parameter int unsigned KW  = $clog2(NWG)
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic [NWG-1:0] fire_i,
  input  logic [2:0]     cnt_i [NWG],
  input  logic [NWG-1:0] accel_i,
  input  logic           accel_only_i,
  output logic           s0_vld_o,
  output logic [KW-1:0]  s0_key_o,
  output logic           s0_accel_o,
  output logic [2:0]     s0_nlyr_o,
  output logic           s1_vld_o,
  output logic [KW-1:0]  s1_key_o,
  output logic           s1_accel_o,
  output logic [2:0]     s1_nlyr_o,
  output logic           veto_o
);
  localparam int unsigned SCW = 3 + 1 + KW;

  function automatic logic [SCW-1:0] score(input logic [2:0] n, input logic acc,
                                           input int unsigned k);
    return {n, ~acc, KW'(NWG - 1 - k)};
  endfunction

  logic           h0, h1;
  logic [KW-1:0]  i0, i1;
  logic [SCW-1:0] sc0, sc1, sc;
  logic           v0_n, v1_n, a0_n, a1_n, veto_n;
  logic [KW-1:0]  k0_n, k1_n;
  logic [2:0]     n0_n, n1_n;

  always_comb begin
    h0 = 1'b0; i0 = '0; sc0 = '0;
    h1 = 1'b0; i1 = '0; sc1 = '0;
    for (int k = 0; k < NWG; k++) begin
      sc = score(cnt_i[k], accel_i[k], k);
      if (fire_i[k] && (!h0 || sc > sc0)) begin
        h0 = 1'b1; sc0 = sc; i0 = KW'(k);
      end
    end
    for (int k = 0; k < NWG; k++) begin
      sc = score(cnt_i[k], accel_i[k], k);
      if (fire_i[k] && (KW'(k) != i0) && (!h1 || sc > sc1)) begin
        h1 = 1'b1; sc1 = sc; i1 = KW'(k);
      end
    end
    v0_n   = h0;
    k0_n   = h0 ? i0 : '0;
    a0_n   = h0 ? accel_i[i0] : 1'b0;
    n0_n   = h0 ? cnt_i[i0] : 3'd0;
    v1_n   = h0 && h1;
    k1_n   = v1_n ? i1 : '0;
    a1_n   = v1_n ? accel_i[i1] : 1'b0;
    n1_n   = v1_n ? cnt_i[i1] : 3'd0;
    veto_n = accel_only_i && h0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      s0_vld_o <= 1'b0; s0_key_o <= '0; s0_accel_o <= 1'b0; s0_nlyr_o <= '0;
      s1_vld_o <= 1'b0; s1_key_o <= '0; s1_accel_o <= 1'b0; s1_nlyr_o <= '0;
      veto_o   <= 1'b0;
    end else begin
      s0_vld_o <= v0_n; s0_key_o <= k0_n; s0_accel_o <= a0_n; s0_nlyr_o <= n0_n;
      s1_vld_o <= v1_n; s1_key_o <= k1_n; s1_accel_o <= a1_n; s1_nlyr_o <= n1_n;
      veto_o   <= veto_n;
    end
  end

  // R8
  slot1_needs_slot0_chk: assert property (@(posedge clk) disable iff (!rst_n)
    s1_vld_o |-> s0_vld_o && (s0_key_o != s1_key_o));
  // R7
  slot_order_chk: assert property (@(posedge clk) disable iff (!rst_n)
    s1_vld_o |-> (s0_nlyr_o > s1_nlyr_o) ||
                 ((s0_nlyr_o == s1_nlyr_o) && (!s0_accel_o || s1_accel_o)));
  // R10
  veto_is_accel_chk: assert property (@(posedge clk) disable iff (!rst_n)
    veto_o |-> s0_vld_o && s0_accel_o);
endmodule

// File: rtl/wire_stub_finder.sv
module wire_stub_finder #(
  parameter int unsigned NWG         = 16,
  parameter int unsigned SW          = 2,
  parameter int unsigned CONFIRM_DLY = 1,
  parameter int unsigned KW          = $clog2(NWG)
) (
  input  logic                                clk,
  input  logic                                rst_n,
  input  logic [wsf_pkg::NLAYER-1:0][NWG-1:0] hits_i,
  input  logic [SW-1:0]                       stretch_i,
  input  logic [2:0]                          pre_min_i,
  input  logic [2:0]                          trg_min_i,
  input  logic                                accel_only_i,
  output logic                                s0_vld_o,
  output logic [KW-1:0]                       s0_key_o,
  output logic                                s0_accel_o,
  output logic [2:0]                          s0_nlyr_o,
  output logic                                s1_vld_o,
  output logic [KW-1:0]                       s1_key_o,
  output logic                                s1_accel_o,
  output logic [2:0]                          s1_nlyr_o,
  output logic                                veto_o
);
  localparam int unsigned NL = wsf_pkg::NLAYER;

  logic [NL-1:0][NWG-1:0] str;
  logic [2:0]             coll [NWG];
  logic [2:0]             acc  [NWG];
  logic [2:0]             kcnt [NWG];
  logic [NWG-1:0]         fire, kacc, blk_ld;
  logic [2:0]             pre_min, trg_min;

  assign pre_min = wsf_pkg::clamp_min(pre_min_i);
  assign trg_min = wsf_pkg::clamp_min(trg_min_i);

  wsf_stretch #(.NWG(NWG), .SW(SW)) u_stretch (
    .clk(clk), .rst_n(rst_n), .hit_i(hits_i), .stretch_i(stretch_i), .str_o(str));

  wsf_layer_count #(.NWG(NWG)) u_count (
    .str_i(str), .coll_o(coll), .acc_o(acc));

  for (genvar k = 0; k < NWG; k++) begin : g_key
    logic lf, rf;
    if (k > 0)       begin : g_l assign lf = fire[k-1]; end
    else             begin : g_l0 assign lf = 1'b0; end
    if (k < NWG - 1) begin : g_r assign rf = fire[k+1]; end
    else             begin : g_r0 assign rf = 1'b0; end
    assign blk_ld[k] = lf | fire[k] | rf;

    wsf_key_engine #(.SW(SW), .CONFIRM_DLY(CONFIRM_DLY)) u_eng (
      .clk(clk), .rst_n(rst_n), .coll_i(coll[k]), .acc_i(acc[k]),
      .accel_only_i(accel_only_i), .pre_min_i(pre_min), .trg_min_i(trg_min),
      .stretch_i(stretch_i), .blk_ld_i(blk_ld[k]),
      .fire_o(fire[k]), .cnt_o(kcnt[k]), .accel_o(kacc[k]));
  end

  wsf_ranker #(.NWG(NWG), .KW(KW)) u_rank (
    .clk(clk), .rst_n(rst_n), .fire_i(fire), .cnt_i(kcnt), .accel_i(kacc),
    .accel_only_i(accel_only_i),
    .s0_vld_o(s0_vld_o), .s0_key_o(s0_key_o), .s0_accel_o(s0_accel_o), .s0_nlyr_o(s0_nlyr_o),
    .s1_vld_o(s1_vld_o), .s1_key_o(s1_key_o), .s1_accel_o(s1_accel_o), .s1_nlyr_o(s1_nlyr_o),
    .veto_o(veto_o));

  // R10
  normal_mode_no_veto_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !$past(accel_only_i) |-> !veto_o);
endmodule

// File: tb/wire_stub_finder_bench.sv
`timescale 1ns/1ps
module wire_stub_finder_bench;
  localparam int NWG = 16;
  localparam int KW  = 4;

  logic clk = 1'b0;
  logic rst_n;
  logic [5:0][NWG-1:0] hits;
  logic [1:0] stretch;
  logic [2:0] pre_min, trg_min;
  logic accel_only;
  logic s0_vld, s0_acc, s1_vld, s1_acc, veto;
  logic [KW-1:0] s0_key, s1_key;
  logic [2:0] s0_n, s1_n;
  int n_chk = 0;
  int n_fail = 0;

  always #2.5 clk = ~clk;

  wire_stub_finder u_wire_stub_finder (
    .clk(clk), .rst_n(rst_n), .hits_i(hits), .stretch_i(stretch),
    .pre_min_i(pre_min), .trg_min_i(trg_min), .accel_only_i(accel_only),
    .s0_vld_o(s0_vld), .s0_key_o(s0_key), .s0_accel_o(s0_acc), .s0_nlyr_o(s0_n),
    .s1_vld_o(s1_vld), .s1_key_o(s1_key), .s1_accel_o(s1_acc), .s1_nlyr_o(s1_n),
    .veto_o(veto));

  function automatic logic [8:0] stub(input logic v, input int key, input logic a, input int n);
    return v ? {1'b1, 4'(key), a, 3'(n)} : 9'd0;
  endfunction

  task automatic chk(input string tag, input logic [15:0] act, input logic [15:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic chk_slots(input string tag, input logic [8:0] e0, input logic [8:0] e1);
    chk({tag, " slot0"}, {7'd0, s0_vld, s0_key, s0_acc, s0_n}, {7'd0, e0});
    chk({tag, " slot1"}, {7'd0, s1_vld, s1_key, s1_acc, s1_n}, {7'd0, e1});
  endtask

  task automatic tick(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  task automatic put_straight(input int key, input logic [5:0] lm);
    for (int l = 0; l < 6; l++) if (lm[l]) hits[l][key] = 1'b1;
  endtask

  task automatic put_coll(input int key, input logic [5:0] lm);
    for (int l = 1; l < 5; l++) if (lm[l]) hits[l][key] = 1'b1;
    if (lm[0]) hits[0][key-1] = 1'b1;
    if (lm[5]) hits[5][key+1] = 1'b1;
  endtask

  task automatic settle();
    hits = '0; accel_only = 1'b0; pre_min = 3'd2; trg_min = 3'd4; stretch = 2'd3;
    tick(8);
  endtask

  task automatic t_reset();
    rst_n = 1'b0; hits = '0; stretch = 2'd3; pre_min = 3'd2; trg_min = 3'd4; accel_only = 1'b0;
    tick(3);
    chk_slots("R1 in reset", 9'd0, 9'd0);
    chk("R1 veto in reset", {15'd0, veto}, 16'd0);
    rst_n = 1'b1;
    tick(1);
    chk_slots("R1 after release", 9'd0, 9'd0);
  endtask

  task automatic t_accel_track();
    put_straight(5, 6'h3f);
    tick(1); hits = '0;
    tick(1);
    chk_slots("R3 no early stub", 9'd0, 9'd0);
    tick(1);
    chk_slots("R5 straight track accel type", stub(1, 5, 1, 6), 9'd0);
    chk("R10 veto low in normal mode", {15'd0, veto}, 16'd0);
    tick(1);
    chk_slots("R3 stub lasts one cycle", 9'd0, 9'd0);
    settle();
  endtask

  task automatic t_coll_track();
    put_coll(8, 6'h3f);
    tick(1); hits = '0;
    tick(2);
    chk_slots("R4 bent track collision type", stub(1, 8, 0, 6), 9'd0);
    settle();
  endtask

  task automatic t_drift();
    put_straight(3, 6'h03); tick(1);
    hits = '0; put_straight(3, 6'h0c); tick(1);
    hits = '0; put_straight(3, 6'h30); tick(1);
    hits = '0;
    chk_slots("R2 drift spread joins at first crossing", stub(1, 3, 1, 4), 9'd0);
    tick(1);
    chk_slots("R9 late layers do not retrigger", 9'd0, 9'd0);
    settle();
  endtask

  task automatic t_expiry();
    int seen = 0;
    put_straight(9, 6'h07); tick(1);
    hits = '0; tick(2);
    put_straight(9, 6'h38); tick(1);
    hits = '0;
    for (int i = 0; i < 10; i++) begin
      if (s0_vld) seen++;
      tick(1);
    end
    chk("R2 expired hits do not combine / R3 failed confirm silent", 16'(seen), 16'd0);
    settle();
  endtask

  task automatic t_thresholds();
    trg_min = 3'd6;
    put_straight(4, 6'h3e); tick(1); hits = '0; tick(2);
    chk_slots("R6 five layers below trigger minimum 6", 9'd0, 9'd0);
    settle();
    trg_min = 3'd5;
    put_straight(4, 6'h3e); tick(1); hits = '0; tick(2);
    chk_slots("R6 five layers meet trigger minimum 5", stub(1, 4, 1, 5), 9'd0);
    settle();
    trg_min = 3'd0; pre_min = 3'd0;
    hits[2][10] = 1'b1; tick(1); hits = '0; tick(2);
    chk_slots("R6 zero minimum acts as one", stub(1, 10, 0, 1), 9'd0);
    settle();
    trg_min = 3'd7; pre_min = 3'd7;
    put_straight(6, 6'h3f); tick(1); hits = '0; tick(2);
    chk_slots("R6 seven minimum acts as six", stub(1, 6, 1, 6), 9'd0);
    settle();
  endtask

  task automatic t_pre_delay();
    pre_min = 3'd5;
    put_straight(11, 6'h0f); tick(1);
    hits = '0; put_straight(11, 6'h30); tick(1);
    hits = '0; tick(1);
    chk_slots("R3 below pretrigger minimum no stub yet", 9'd0, 9'd0);
    tick(1);
    chk_slots("R3 pretrigger minimum sets crossing", stub(1, 11, 1, 6), 9'd0);
    settle();
  endtask

  task automatic t_ranking();
    put_straight(2, 6'h3f); put_coll(12, 6'h3f);
    tick(1); hits = '0; tick(2);
    chk_slots("R7 equal counts collision first", stub(1, 12, 0, 6), stub(1, 2, 1, 6));
    settle();
    put_straight(2, 6'h3f); put_straight(7, 6'h3f); put_coll(12, 6'h37);
    tick(1); hits = '0; tick(2);
    chk_slots("R8 three stubs best two by count then key", stub(1, 2, 1, 6), stub(1, 7, 1, 6));
    settle();
  endtask

  task automatic t_block();
    put_straight(5, 6'h3f); tick(2);
    put_straight(6, 6'h3f); tick(1);
    hits = '0;
    chk_slots("R9 first stub reported", stub(1, 5, 1, 6), 9'd0);
    begin
      int seen = 0;
      for (int i = 0; i < 7; i++) begin
        tick(1);
        if (s0_vld) seen++;
      end
      chk("R9 neighbour blocked", 16'(seen), 16'd0);
    end
    settle();
    put_straight(5, 6'h3f); tick(2);
    put_straight(8, 6'h3f); tick(1);
    hits = '0;
    chk_slots("R9 first stub control", stub(1, 5, 1, 6), 9'd0);
    tick(2);
    chk_slots("R9 non-neighbour free", stub(1, 8, 1, 6), 9'd0);
    settle();
  endtask

  task automatic t_accel_mode();
    accel_only = 1'b1;
    put_coll(8, 6'h3f); tick(1); hits = '0; tick(2);
    chk_slots("R10 accel-only uses straight envelope", stub(1, 8, 1, 4), 9'd0);
    chk("R10 veto flag", {15'd0, veto}, 16'd1);
    tick(6);
    trg_min = 3'd5;
    put_coll(8, 6'h3f); tick(1); hits = '0; tick(2);
    chk_slots("R10 collision envelope ignored", 9'd0, 9'd0);
    chk("R10 no veto without stub", {15'd0, veto}, 16'd0);
    settle();
  endtask

  initial begin
    #40000;
    n_fail++;
    $display("FAIL watchdog actual=running expected=finished");
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
    $finish;
  end

  initial begin
    t_reset();
    settle();
    t_accel_track();
    t_coll_track();
    t_drift();
    t_expiry();
    t_thresholds();
    t_pre_delay();
    t_ranking();
    t_block();
    t_accel_mode();
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
    $finish;
  end
endmodule